// File: doc/BRIEF.md
# Masked Pattern Match Interrupt Controller

This block watches a 40-bit input bus and compares it against a programmed pattern. The bus is split into five 8-bit slices. Each slice has its own match-value register and its own don't-care mask register, and each slice produces its own equal flag. When every slice reports equal in the same cycle, the block records a sticky compare-match cause in an interrupt status register. Two module-detect inputs (left and right) are recorded as causes in the same register. The interrupt output is raised while any cause is pending.

The host programs the block through a single 8-bit write port. The port has a target select and a slice index, so the value and mask registers are loaded one slice at a time. The same port loads an 8-bit control register. That register holds active-low clear bits for each cause and for all causes, plus three mode bits that are driven out to neighbouring logic.

The control register resets to zero. Because the clear bits are active low, every cause is held cleared after reset until the host releases the clears. The bus and the detect inputs are registered once before they are used. A value present on the bus before clock edge k therefore appears in the status register after edge k+1.

Top module: `pattern_match_irq`

## Requirements
- R1: While `rst_n` is low and after its release, `status_o`, `irq`, `mode_enmux`, `mode_clkmux` and `mode_thresh` are all 0. The control register is all zeros, so every clear is asserted.
- R2: A bus bit whose mask bit is 1 always counts as equal. Slice i covers bus bits 8i+7:8i, and bit j of slice i's mask qualifies bus bit 8i+j.
- R3: Status bit 0 (match cause) is set only when all five slices are equal on their unmasked bits in the same cycle. A single unmasked mismatching bit in any slice prevents it. A bus value sampled at edge k sets the bit at edge k+1.
- R4: Once set, a cause bit stays set after its source goes away, until the cause is cleared.
- R5: Clear decoding is active low: control bit 0 clears the match cause and control bit 3 clears all causes. While a clear is asserted, the affected cause stays 0 even if its source is active in the same cycle.
- R6: `det_left` sets status bit 1 and `det_right` sets status bit 2, with the same one-register input latency as the bus. They are cleared by control bits 1 and 2 respectively (active low) or by control bit 3.
- R7: A write with `wr_en`=1 targets a register according to `wr_sel`: 0 loads the match value of slice `wr_slice`, 1 loads the mask of slice `wr_slice`, 2 loads the control register, and 3 is ignored. Value and mask writes with `wr_slice` of 5, 6 or 7 change nothing.
- R8: `irq` is 1 exactly when at least one status bit is 1.
- R9: `mode_enmux`, `mode_clkmux` and `mode_thresh` reflect control bits 4, 5 and 6, from the cycle after the control write.
- R10: `status_o` bits 7:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 value, 1 mask, 2 control, 3 none |
| wr_slice | input | 3 | Slice index for value and mask writes |
| wr_data | input | 8 | Write data |
| bus_in | input | 40 | Observed bus |
| det_left | input | 1 | Left module-detect source |
| det_right | input | 1 | Right module-detect source |
| status_o | output | 8 | Interrupt status: bit 0 match, bit 1 left, bit 2 right |
| irq | output | 1 | OR of pending causes |
| mode_enmux | output | 1 | Control bit 4 |
| mode_clkmux | output | 1 | Control bit 5 |
| mode_thresh | output | 1 | Control bit 6 |

## Verification
The assertions assume that `bus_in`, `det_left`, `det_right` and the write port are synchronous to `clk` and stable around its rising edge. They also assume that a control write lands in the register on the same edge that sees `wr_en`. The bench drives every input only on the falling edge, so each value is settled a half period before it is sampled. It also never toggles reset mid-run. Random traffic keeps the clear bits mostly released and the bus mostly near the programmed pattern, so the set, hold and clear paths are all exercised.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

  typedef enum logic [1:0] {
    SEL_VALUE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } pmi_sel_e;

  // Control word, bit 0 at the bottom
  typedef struct packed {
    logic spare;
    logic thresh;
    logic clkmux;
    logic enmux;
    logic clr_all_n;
    logic clr_right_n;
    logic clr_left_n;
    logic clr_match_n;
  } pmi_ctrl_t;

  localparam int CAUSES     = 3;
  localparam int CAUSE_MTCH = 0;
  localparam int CAUSE_LEFT = 1;
  localparam int CAUSE_RGHT = 2;
  localparam int STAT_W     = 8;

  // Per-cause clear request decoded from the active-low control bits
  function automatic logic [CAUSES-1:0] cause_clears(input pmi_ctrl_t c);
    logic [CAUSES-1:0] r;
    r[CAUSE_MTCH] = ~c.clr_match_n | ~c.clr_all_n;
    r[CAUSE_LEFT] = ~c.clr_left_n  | ~c.clr_all_n;
    r[CAUSE_RGHT] = ~c.clr_right_n | ~c.clr_all_n;
    return r;
  endfunction

endpackage

// File: rtl/pmi_slice_cmp.sv
module pmi_slice_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_value,
  input  logic         ld_mask,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] bus_slice,
  output logic         eq_o
);

  logic [W-1:0] value_q;
  logic [W-1:0] dc_q;

  // Equal when every bit either agrees or is marked don't-care
  function automatic logic slice_hit(input logic [W-1:0] v,
                                     input logic [W-1:0] ref_v,
                                     input logic [W-1:0] dc);
    return &((v ~^ ref_v) | dc);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dc_q    <= '0;
    end else begin
      if (ld_value) value_q <= wr_val;
      if (ld_mask)  dc_q    <= wr_val;
    end
  end

  assign eq_o = slice_hit(bus_slice, value_q, dc_q);

endmodule

// File: rtl/pmi_ctrl_reg.sv
module pmi_ctrl_reg
  import pmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] d_i,
  output pmi_ctrl_t  ctrl_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (wr_i) ctrl_o <= pmi_ctrl_t'(d_i);
  end

endmodule

// File: rtl/pmi_cause_latch.sv
module pmi_cause_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[g] <= 1'b0;
      else if (clr_i[g]) pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/pattern_match_irq.sv
module pattern_match_irq
  import pmi_pkg::*;
#(
  parameter int SLICES  = 5,
  parameter int SLICE_W = 8,
  localparam int BUS_W  = SLICES * SLICE_W,
  localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [IDX_W-1:0]   wr_slice,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [BUS_W-1:0]   bus_in,
  input  logic               det_left,
  input  logic               det_right,
  output logic [STAT_W-1:0]  status_o,
  output logic               irq,
  output logic               mode_enmux,
  output logic               mode_clkmux,
  output logic               mode_thresh
);

  // Input capture stage
  logic [BUS_W-1:0] bus_q;
  logic [1:0]       det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      det_q <= '0;
    end else begin
      bus_q <= bus_in;
      det_q <= {det_right, det_left};
    end
  end

  // Write decode
  logic wr_value, wr_mask, wr_ctrl;
  assign wr_value = wr_en && (pmi_sel_e'(wr_sel) == SEL_VALUE);
  assign wr_mask  = wr_en && (pmi_sel_e'(wr_sel) == SEL_MASK);
  assign wr_ctrl  = wr_en && (pmi_sel_e'(wr_sel) == SEL_CTRL);

  // Slice compares
  logic [SLICES-1:0] eq_vec;
  logic              all_eq;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic hit_idx;
    assign hit_idx = (wr_slice == IDX_W'(s));
    pmi_slice_cmp #(.W(SLICE_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_value  (wr_value && hit_idx),
      .ld_mask   (wr_mask && hit_idx),
      .wr_val    (wr_data),
      .bus_slice (bus_q[s*SLICE_W +: SLICE_W]),
      .eq_o      (eq_vec[s])
    );
  end

  assign all_eq = &eq_vec;

  // Control register
  pmi_ctrl_t  ctrl;
  logic [7:0] ctrl_bits;

  pmi_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_ctrl),
    .d_i    (wr_data[7:0]),
    .ctrl_o (ctrl)
  );

  assign ctrl_bits   = ctrl;
  assign mode_enmux  = ctrl.enmux;
  assign mode_clkmux = ctrl.clkmux;
  assign mode_thresh = ctrl.thresh;

  // Cause latching
  logic [CAUSES-1:0] set_vec, clr_vec, pend;
  logic              clr_match, clr_left;

  assign clr_vec   = cause_clears(ctrl);
  assign clr_match = clr_vec[CAUSE_MTCH];
  assign clr_left  = clr_vec[CAUSE_LEFT];

  always_comb begin
    set_vec             = '0;
    set_vec[CAUSE_MTCH] = all_eq;
    set_vec[CAUSE_LEFT] = det_q[0];
    set_vec[CAUSE_RGHT] = det_q[1];
  end

  pmi_cause_latch #(.N(CAUSES)) u_causes (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  assign status_o = {{(STAT_W-CAUSES){1'b0}}, pend};
  assign irq      = |pend;

endmodule

// File: rtl/pmi_match_chk.sv
module pmi_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       all_eq,
  input logic       clr_match,
  input logic       clr_left,
  input logic       det_left_q,
  input logic [7:0] status,
  input logic       wr_ctrl,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_bits
);

  // R3
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_eq && !clr_match |=> status[0]);

  // R3
  match_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(all_eq));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !clr_match |=> status[0]);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_match |=> !status[0]);

  // R6
  left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_left_q && !clr_left |=> status[1]);

  // R7
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_bits == $past(wr_data));

  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:3] == 5'd0);

endmodule

bind pattern_match_irq pmi_match_chk u_pmi_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .all_eq     (all_eq),
  .clr_match  (clr_match),
  .clr_left   (clr_left),
  .det_left_q (det_q[0]),
  .status     (status_o),
  .wr_ctrl    (wr_ctrl),
  .wr_data    (wr_data[7:0]),
  .ctrl_bits  (ctrl_bits)
);

// File: tb/pattern_match_irq_bench.sv
`timescale 1ns/1ps
module pattern_match_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [2:0]  wr_slice = '0;
  logic [7:0]  wr_data = '0;
  logic [39:0] bus_in = '0;
  logic        det_left = 1'b0;
  logic        det_right = 1'b0;
  logic [7:0]  status_o;
  logic        irq, mode_enmux, mode_clkmux, mode_thresh;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit live = 0;

  localparam logic [39:0] PAT = 40'hA5_3C_0F_F0_96;

  always #2.5 clk = ~clk;

  pattern_match_irq u_pattern_match_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_slice(wr_slice), .wr_data(wr_data), .bus_in(bus_in),
    .det_left(det_left), .det_right(det_right), .status_o(status_o),
    .irq(irq), .mode_enmux(mode_enmux), .mode_clkmux(mode_clkmux),
    .mode_thresh(mode_thresh)
  );

  // Behavioural reference model
  logic [7:0]  val_m [5];
  logic [7:0]  msk_m [5];
  logic [7:0]  ctl_m;
  logic [39:0] busd_m;
  logic        dl_m, dr_m;
  logic [2:0]  st_m;

  initial begin
    for (int i = 0; i < 5; i++) begin val_m[i] = 0; msk_m[i] = 0; end
    ctl_m = 0; busd_m = 0; dl_m = 0; dr_m = 0; st_m = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin val_m[i] = 0; msk_m[i] = 0; end
      ctl_m = 0; busd_m = 0; dl_m = 0; dr_m = 0; st_m = 0;
    end else begin
      bit hit;
      bit kill_all;
      logic [2:0] nxt;
      hit = 1;
      for (int i = 0; i < 40; i++)
        if (!msk_m[i/8][i%8] && (busd_m[i] !== val_m[i/8][i%8])) hit = 0;
      kill_all = (ctl_m[3] == 1'b0);
      nxt[0] = (kill_all || !ctl_m[0]) ? 1'b0 : (st_m[0] | hit);
      nxt[1] = (kill_all || !ctl_m[1]) ? 1'b0 : (st_m[1] | dl_m);
      nxt[2] = (kill_all || !ctl_m[2]) ? 1'b0 : (st_m[2] | dr_m);
      if (wr_en) begin
        if (wr_sel == 2'd0 && wr_slice < 5) val_m[wr_slice] = wr_data;
        if (wr_sel == 2'd1 && wr_slice < 5) msk_m[wr_slice] = wr_data;
        if (wr_sel == 2'd2) ctl_m = wr_data;
      end
      busd_m = bus_in; dl_m = det_left; dr_m = det_right;
      st_m = nxt;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(status_o[0] === st_m[0], "R3 match cause", 64'(status_o[0]), 64'(st_m[0]));
      check(status_o[2:1] === st_m[2:1], "R6 detect causes", 64'(status_o[2:1]), 64'(st_m[2:1]));
      check(irq === (|st_m), "R8 irq", 64'(irq), 64'(|st_m));
      check({mode_thresh, mode_clkmux, mode_enmux} === ctl_m[6:4], "R9 mode bits",
            64'({mode_thresh, mode_clkmux, mode_enmux}), 64'(ctl_m[6:4]));
      check(status_o[7:3] === 5'd0, "R10 spare bits", 64'(status_o[7:3]), 64'd0);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_slice = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state with reset held
    check(status_o === 8'd0 && irq === 1'b0, "R1 reset status", 64'({irq, status_o}), 64'd0);
    rst_n = 1;
    live = 1;
    idle(2);
    check({mode_thresh, mode_clkmux, mode_enmux, irq, status_o} === 12'd0,
          "R1 after release", 64'({mode_thresh, mode_clkmux, mode_enmux, irq, status_o}), 64'd0);

    // Program pattern, release clears
    for (int i = 0; i < 5; i++) wr(2'd0, 3'(i), PAT[i*8 +: 8]);
    wr(2'd2, 0, 8'h0F);
    @(negedge clk); bus_in = PAT;
    @(negedge clk); bus_in = 40'h0;
    idle(2);
    check(status_o[0] === 1'b1, "R3 full match", 64'(status_o[0]), 64'd1);
    idle(5);
    check(status_o[0] === 1'b1, "R4 sticky", 64'(status_o[0]), 64'd1);
    check(irq === 1'b1, "R8 irq raised", 64'(irq), 64'd1);

    wr(2'd2, 0, 8'h0E); wr(2'd2, 0, 8'h0F);
    idle(2);
    check(status_o[0] === 1'b0, "R5 match clear", 64'(status_o[0]), 64'd0);

    // One unmasked mismatching bit in slice 4
    @(negedge clk); bus_in = PAT ^ (40'd1 << 33);
    idle(4);
    check(status_o[0] === 1'b0, "R3 one-bit miss", 64'(status_o[0]), 64'd0);
    wr(2'd1, 3'd4, 8'h02);
    idle(3);
    check(status_o[0] === 1'b1, "R2 masked bit", 64'(status_o[0]), 64'd1);

    // Clear held while source stays active
    wr(2'd2, 0, 8'h0E);
    idle(4);
    check(status_o[0] === 1'b0, "R5 clear wins", 64'(status_o[0]), 64'd0);
    wr(2'd2, 0, 8'h0F);
    idle(3);
    check(status_o[0] === 1'b1, "R5 release resets", 64'(status_o[0]), 64'd1);

    // Out-of-range slice writes are ignored
    wr(2'd2, 0, 8'h0E); wr(2'd2, 0, 8'h0F);
    wr(2'd0, 3'd5, 8'h00); wr(2'd0, 3'd6, 8'h00); wr(2'd0, 3'd7, 8'h00);
    wr(2'd1, 3'd5, 8'h00); wr(2'd3, 3'd0, 8'h00);
    idle(3);
    check(status_o[0] === 1'b1, "R7 ignored writes", 64'(status_o[0]), 64'd1);

    // Detect sources
    @(negedge clk); det_left = 1;
    @(negedge clk); det_left = 0;
    idle(2);
    check(status_o[1] === 1'b1, "R6 left detect", 64'(status_o[1]), 64'd1);
    @(negedge clk); det_right = 1;
    @(negedge clk); det_right = 0;
    idle(2);
    check(status_o[2] === 1'b1, "R6 right detect", 64'(status_o[2]), 64'd1);
    wr(2'd2, 0, 8'h0B);
    idle(2);
    check(status_o[2:0] === 3'b011, "R6 right clear", 64'(status_o[2:0]), 64'h3);

    // General clear with all sources active
    det_left = 1; det_right = 1;
    wr(2'd2, 0, 8'h07);
    idle(3);
    check(status_o === 8'd0 && irq === 1'b0, "R5 general clear", 64'({irq, status_o}), 64'd0);
    det_left = 0; det_right = 0;

    wr(2'd2, 0, 8'h7F);
    idle(1);
    check({mode_thresh, mode_clkmux, mode_enmux} === 3'b111, "R9 modes on",
          64'({mode_thresh, mode_clkmux, mode_enmux}), 64'h7);
    wr(2'd2, 0, 8'h2F);
    idle(1);
    check({mode_thresh, mode_clkmux, mode_enmux} === 3'b010, "R9 clkmux only",
          64'({mode_thresh, mode_clkmux, mode_enmux}), 64'h2);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en = 0; wr_sel = 2'd3;
      case ($urandom_range(3))
        0: bus_in = PAT;
        1: bus_in = PAT ^ (40'd1 << $urandom_range(39));
        2: bus_in = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
        default: bus_in = PAT ^ (40'd3 << $urandom_range(38));
      endcase
      det_left  = ($urandom_range(15) == 0);
      det_right = ($urandom_range(15) == 0);
      if ($urandom_range(7) == 0) begin
        wr_en = 1;
        wr_sel = 2'($urandom_range(3));
        wr_slice = 3'($urandom_range(7));
        wr_data = 8'($urandom);
        if (wr_sel == 2'd2 && $urandom_range(3) != 0) wr_data = wr_data | 8'h0F;
        if (wr_sel == 2'd0 && $urandom_range(1) == 0 && wr_slice < 5)
          wr_data = PAT[wr_slice*8 +: 8];
      end
    end
    @(negedge clk);
    wr_en = 0;
    idle(3);
    done = 1;
    live = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule